// File: doc/BRIEF.md
# Debug Entry Context Capture

This block keeps the processor context that a debugger needs once the core stops in its halted debug mode. While the core runs, the block follows the stream of bus cycles and retired instructions. From them it keeps the address of the most recent bus cycle, the program counter of the last completed instruction and the address where fetching will resume. Three cause inputs stop the core: a double bus fault, a software background instruction and a hardware breakpoint. On entry the block stores a 32-bit code for the cause in a scratch register.

While halted, a debugger issues one command per cycle through a simple port, and a 2-bit select picks one of the four context registers. Debug commands reuse the scratch register as a staging register, so the cause code is only valid until the first command that is not a read of the scratch register itself. A resume request leaves debug mode. The block then hands the return address to the fetch logic and flags an address error if that address is odd.

Top module: `dbg_ctx_capture`

## Requirements
- R1: After synchronous reset, `halted`, `cause_valid`, `dbg_rvalid`, `resume_fire` and `addr_err` are 0, and all four context registers read as zero (so `fetch_addr` is 0).
- R2: Entry through the background-instruction input alone loads the scratch register with 0x00000001.
- R3: Entry through the breakpoint input, with no double fault, loads the scratch register with 0x00000000.
- R4: Entry through the double-fault input loads the scratch register with `ssw_in` in bits 31:16 and 0xFFFF in bits 15:0.
- R5: When several cause inputs are high in the same cycle, the double fault wins over the breakpoint, and the breakpoint wins over the background instruction.
- R6: A double-fault entry with `init_fetch` high sets the current-instruction PC to 0xFFFFFFFF, even if an instruction retires in the same cycle. Without `init_fetch`, that PC keeps the last retired instruction. No other path leaves bit 0 of that register set.
- R7: While running, each retire loads the current-instruction PC with `retire_pc` (bit 0 cleared) and the return PC with `retire_next_pc`. Retires are ignored while halted. A debugger write to the current-instruction PC also clears bit 0.
- R8: While running, every bus cycle, including one in the same cycle as entry, overwrites the fault address register. After a double fault it therefore holds the last bus cycle's address. Bus cycles are ignored while halted.
- R9: Select codes are 0 scratch, 1 fault address, 2 return PC and 3 current-instruction PC. Read data and `dbg_rvalid` appear the cycle after a read command. Commands are ignored while not halted.
- R10: Every halted command other than a read of the scratch register loads the scratch register with the value transferred (the read value or the write data) and clears `cause_valid`. A read of the scratch register changes neither.
- R11: `resume_req` while halted raises `resume_fire` in the same cycle, with `fetch_addr` equal to the return PC and `addr_err` equal to its bit 0. `halted` falls at the next edge.
- R12: Any cause input while running sets `halted` and `cause_valid` at the next edge. Cause inputs while halted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_dbl_fault | input | 1 | Double bus fault cause |
| ent_bgnd | input | 1 | Background instruction cause |
| ent_bkpt | input | 1 | Hardware breakpoint cause |
| ssw_in | input | 16 | Special status word for a double fault |
| init_fetch | input | 1 | Fault happened during the initial stack/PC fetch |
| bus_cyc_valid | input | 1 | A bus cycle completes this cycle |
| bus_cyc_addr | input | 32 | Address of that bus cycle |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | 32 | Address of the first word of the retired instruction |
| retire_next_pc | input | 32 | Next fetch address after it |
| dbg_valid | input | 1 | Debugger command strobe |
| dbg_write | input | 1 | 1 write, 0 read |
| dbg_sel | input | 2 | Register select |
| dbg_wdata | input | 32 | Write data |
| dbg_rdata | output | 32 | Read data |
| dbg_rvalid | output | 1 | Read data valid |
| resume_req | input | 1 | Leave debug mode |
| resume_fire | output | 1 | Resume accepted this cycle |
| fetch_addr | output | 32 | Return PC for fetch |
| addr_err | output | 1 | Return PC is odd |
| halted | output | 1 | Core is in debug mode |
| cause_valid | output | 1 | Scratch register still holds the cause code |

## Verification
Entry into debug mode can fall in the same cycle as a bus cycle and an instruction retire. The bench drives a double fault with `init_fetch` together with both. It then reads back the fault address register, which must hold the coincident bus address, and the current-instruction PC, which must hold the 0xFFFFFFFF marker rather than the retired address. Coincident cause inputs are also driven together, and the scratch code read first after entry shows which cause won.

// File: rtl/dbg_ctx_pkg.sv
package dbg_ctx_pkg;

    localparam int XLEN  = 32;
    localparam int HLEN  = XLEN / 2;
    localparam int SEL_W = 2;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [HLEN-1:0] half_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_TMP = 2'd0,
        SEL_FAR = 2'd1,
        SEL_RPC = 2'd2,
        SEL_PCC = 2'd3
    } ctx_sel_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_BGND = 2'd1,
        CAUSE_BKPT = 2'd2,
        CAUSE_DBL  = 2'd3
    } cause_e;

    typedef struct packed {
        logic     valid;
        logic     write;
        ctx_sel_e sel;
        word_t    wdata;
    } dbg_cmd_t;

    localparam word_t PC_INIT_FAULT = {XLEN{1'b1}};

    function automatic cause_e pick_cause(input logic dbl, input logic bkpt, input logic bgnd);
        if (dbl)       return CAUSE_DBL;
        else if (bkpt) return CAUSE_BKPT;
        else if (bgnd) return CAUSE_BGND;
        else           return CAUSE_NONE;
    endfunction

    function automatic word_t cause_code(input cause_e c, input half_t ssw);
        case (c)
            CAUSE_DBL:  return {ssw, {HLEN{1'b1}}};
            CAUSE_BGND: return word_t'(1);
            default:    return '0;
        endcase
    endfunction

    function automatic word_t even(input word_t v);
        return {v[XLEN-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/dbg_cause_sel.sv
module dbg_cause_sel
    import dbg_ctx_pkg::*;
(
    input  logic  running,
    input  logic  dbl,
    input  logic  bkpt,
    input  logic  bgnd,
    input  half_t ssw,
    output logic  enter,
    output logic  enter_dbl,
    output word_t code
);
    cause_e winner;

    always_comb begin
        winner    = pick_cause(dbl, bkpt, bgnd);
        enter     = running && (winner != CAUSE_NONE);
        enter_dbl = running && (winner == CAUSE_DBL);
        code      = cause_code(winner, ssw);
    end
endmodule

// File: rtl/dbg_fault_addr.sv
module dbg_fault_addr
    import dbg_ctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  word_t cap_addr,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t far_q
);
    always_ff @(posedge clk) begin
        if (rst)         far_q <= '0;
        else if (cap_en) far_q <= cap_addr;
        else if (wr_en)  far_q <= wr_data;
    end
endmodule

// File: rtl/dbg_pc_track.sv
module dbg_pc_track
    import dbg_ctx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  retire_en,
    input  word_t retire_pc,
    input  word_t retire_next,
    input  logic  init_fault,
    input  logic  rpc_wr,
    input  logic  pcc_wr,
    input  word_t wdata,
    output word_t rpc_q,
    output word_t pcc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rpc_q <= '0;
            pcc_q <= '0;
        end else begin
            if (retire_en)   rpc_q <= retire_next;
            else if (rpc_wr) rpc_q <= wdata;

            if (init_fault)     pcc_q <= PC_INIT_FAULT;
            else if (retire_en) pcc_q <= even(retire_pc);
            else if (pcc_wr)    pcc_q <= even(wdata);
        end
    end
endmodule

// File: rtl/dbg_ctx_capture.sv
module dbg_ctx_capture
    import dbg_ctx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ent_dbl_fault,
    input  logic        ent_bgnd,
    input  logic        ent_bkpt,
    input  logic [15:0] ssw_in,
    input  logic        init_fetch,
    input  logic        bus_cyc_valid,
    input  logic [31:0] bus_cyc_addr,
    input  logic        retire_valid,
    input  logic [31:0] retire_pc,
    input  logic [31:0] retire_next_pc,
    input  logic        dbg_valid,
    input  logic        dbg_write,
    input  logic [1:0]  dbg_sel,
    input  logic [31:0] dbg_wdata,
    output logic [31:0] dbg_rdata,
    output logic        dbg_rvalid,
    input  logic        resume_req,
    output logic        resume_fire,
    output logic [31:0] fetch_addr,
    output logic        addr_err,
    output logic        halted,
    output logic        cause_valid
);
    logic     halted_q;
    logic     cause_valid_q;
    word_t    tmp_q;
    word_t    far_q;
    word_t    rpc_q;
    word_t    pcc_q;
    word_t    rdata_q;
    logic     rvalid_q;

    logic     running;
    logic     enter;
    logic     enter_dbl;
    word_t    code;
    dbg_cmd_t cmd;
    logic     cmd_fire;
    logic     tmp_read;
    word_t    rd_mux;
    word_t    xfer;

    assign running = !halted_q;

    always_comb begin
        cmd.valid = dbg_valid;
        cmd.write = dbg_write;
        cmd.sel   = ctx_sel_e'(dbg_sel);
        cmd.wdata = dbg_wdata;
    end

    assign cmd_fire = halted_q && cmd.valid;
    assign tmp_read = !cmd.write && (cmd.sel == SEL_TMP);

    dbg_cause_sel u_cause (
        .running   (running),
        .dbl       (ent_dbl_fault),
        .bkpt      (ent_bkpt),
        .bgnd      (ent_bgnd),
        .ssw       (ssw_in),
        .enter     (enter),
        .enter_dbl (enter_dbl),
        .code      (code)
    );

    dbg_fault_addr u_far (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (running && bus_cyc_valid),
        .cap_addr (bus_cyc_addr),
        .wr_en    (cmd_fire && cmd.write && cmd.sel == SEL_FAR),
        .wr_data  (cmd.wdata),
        .far_q    (far_q)
    );

    dbg_pc_track u_pc (
        .clk         (clk),
        .rst         (rst),
        .retire_en   (running && retire_valid),
        .retire_pc   (retire_pc),
        .retire_next (retire_next_pc),
        .init_fault  (enter_dbl && init_fetch),
        .rpc_wr      (cmd_fire && cmd.write && cmd.sel == SEL_RPC),
        .pcc_wr      (cmd_fire && cmd.write && cmd.sel == SEL_PCC),
        .wdata       (cmd.wdata),
        .rpc_q       (rpc_q),
        .pcc_q       (pcc_q)
    );

    always_comb begin
        case (cmd.sel)
            SEL_TMP: rd_mux = tmp_q;
            SEL_FAR: rd_mux = far_q;
            SEL_RPC: rd_mux = rpc_q;
            default: rd_mux = pcc_q;
        endcase
        xfer = cmd.write ? cmd.wdata : rd_mux;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q      <= 1'b0;
            cause_valid_q <= 1'b0;
            tmp_q         <= '0;
            rdata_q       <= '0;
            rvalid_q      <= 1'b0;
        end else begin
            if (enter)            halted_q <= 1'b1;
            else if (resume_fire) halted_q <= 1'b0;

            if (enter) begin
                tmp_q         <= code;
                cause_valid_q <= 1'b1;
            end else if (cmd_fire && !tmp_read) begin
                tmp_q         <= xfer;
                cause_valid_q <= 1'b0;
            end

            rvalid_q <= cmd_fire && !cmd.write;
            if (cmd_fire && !cmd.write) rdata_q <= rd_mux;
        end
    end

    assign resume_fire = halted_q && resume_req;
    assign fetch_addr  = rpc_q;
    assign addr_err    = resume_fire && rpc_q[0];
    assign halted      = halted_q;
    assign cause_valid = cause_valid_q;
    assign dbg_rdata   = rdata_q;
    assign dbg_rvalid  = rvalid_q;
endmodule

// File: rtl/dbg_ctx_capture_chk.sv
module dbg_ctx_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        ent_dbl_fault,
    input logic        ent_bgnd,
    input logic        ent_bkpt,
    input logic        dbg_valid,
    input logic        dbg_write,
    input logic [1:0]  dbg_sel,
    input logic        dbg_rvalid,
    input logic        resume_fire,
    input logic        halted,
    input logic        cause_valid,
    input logic [31:0] tmp_q,
    input logic [31:0] far_q,
    input logic [31:0] pcc_q
);
    assert_entry_halts_R12: assert property (@(posedge clk) disable iff (rst)
        (!halted && (ent_dbl_fault || ent_bgnd || ent_bkpt)) |=> (halted && cause_valid));

    assert_dbl_low_half_R4: assert property (@(posedge clk) disable iff (rst)
        (!halted && ent_dbl_fault) |=> (tmp_q[15:0] == 16'hFFFF));

    assert_pcc_odd_only_marker_R6: assert property (@(posedge clk) disable iff (rst)
        pcc_q[0] |-> (pcc_q == 32'hFFFF_FFFF));

    assert_rvalid_source_R9: assert property (@(posedge clk) disable iff (rst)
        dbg_rvalid |-> $past(halted && dbg_valid && !dbg_write));

    assert_far_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (halted && !(dbg_valid && dbg_write && dbg_sel == 2'd1)) |=> $stable(far_q));

    assert_resume_leaves_R11: assert property (@(posedge clk) disable iff (rst)
        resume_fire |=> !halted);

    assert_cause_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        (halted && dbg_valid && (dbg_write || dbg_sel != 2'd0)) |=> !cause_valid);
endmodule

bind dbg_ctx_capture dbg_ctx_capture_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ent_dbl_fault (ent_dbl_fault),
    .ent_bgnd      (ent_bgnd),
    .ent_bkpt      (ent_bkpt),
    .dbg_valid     (dbg_valid),
    .dbg_write     (dbg_write),
    .dbg_sel       (dbg_sel),
    .dbg_rvalid    (dbg_rvalid),
    .resume_fire   (resume_fire),
    .halted        (halted),
    .cause_valid   (cause_valid),
    .tmp_q         (tmp_q),
    .far_q         (far_q),
    .pcc_q         (pcc_q)
);

// File: tb/tb_dbg_ctx_capture.sv
`timescale 1ns/1ps
module tb_dbg_ctx_capture;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ent_dbl_fault = 1'b0, ent_bgnd = 1'b0, ent_bkpt = 1'b0;
    logic [15:0] ssw_in = '0;
    logic        init_fetch = 1'b0;
    logic        bus_cyc_valid = 1'b0;
    logic [31:0] bus_cyc_addr = '0;
    logic        retire_valid = 1'b0;
    logic [31:0] retire_pc = '0, retire_next_pc = '0;
    logic        dbg_valid = 1'b0, dbg_write = 1'b0;
    logic [1:0]  dbg_sel = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        dbg_rvalid;
    logic        resume_req = 1'b0;
    logic        resume_fire;
    logic [31:0] fetch_addr;
    logic        addr_err;
    logic        halted;
    logic        cause_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_ctx_capture dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val, output logic vld);
        dbg_valid = 1'b1; dbg_write = 1'b0; dbg_sel = sel;
        step();
        dbg_valid = 1'b0;
        val = dbg_rdata;
        vld = dbg_rvalid;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        logic        k;
        rd(sel, v, k);
        chk({req, " rvalid"}, {31'd0, k}, 32'd1);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        dbg_valid = 1'b1; dbg_write = 1'b1; dbg_sel = sel; dbg_wdata = d;
        step();
        dbg_valid = 1'b0; dbg_write = 1'b0;
    endtask

    task automatic enter(input logic d, input logic k, input logic g, input logic [15:0] s, input logic ini);
        ent_dbl_fault = d; ent_bkpt = k; ent_bgnd = g; ssw_in = s; init_fetch = ini;
        step();
        ent_dbl_fault = 0; ent_bkpt = 0; ent_bgnd = 0; init_fetch = 0;
    endtask

    task automatic retire(input logic [31:0] pc, input logic [31:0] nxt);
        retire_valid = 1'b1; retire_pc = pc; retire_next_pc = nxt;
        step();
        retire_valid = 1'b0;
    endtask

    task automatic bus(input logic [31:0] a);
        bus_cyc_valid = 1'b1; bus_cyc_addr = a;
        step();
        bus_cyc_valid = 1'b0;
    endtask

    task automatic resume(input string req, input logic [31:0] exp_pc, input logic exp_err);
        resume_req = 1'b1;
        #0.5;
        chk({req, " resume_fire"}, {31'd0, resume_fire}, 32'd1);
        chk({req, " fetch_addr"}, fetch_addr, exp_pc);
        chk({req, " addr_err"}, {31'd0, addr_err}, {31'd0, exp_err});
        @(posedge clk); #1;
        resume_req = 1'b0;
        chk({req, " halted after resume"}, {31'd0, halted}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 halted", {31'd0, halted}, 32'd0);
        chk("R1 cause_valid", {31'd0, cause_valid}, 32'd0);
        chk("R1 rvalid", {31'd0, dbg_rvalid}, 32'd0);
        chk("R1 fetch_addr", fetch_addr, 32'd0);
        chk("R1 resume_fire", {31'd0, resume_fire}, 32'd0);
        enter(0, 1, 0, 16'h0, 0);
        rd_chk("R1 far reset", 2'd1, 32'd0);
        rd_chk("R1 pcc reset", 2'd3, 32'd0);
        resume("R1", 32'd0, 1'b0);
    endtask

    task automatic t_background();
        retire(32'h0000_1000, 32'h0000_1004);
        retire(32'h0000_3001, 32'h0000_3004);
        bus(32'h0000_2000);
        enter(0, 0, 1, 16'h1234, 0);
        chk("R12 halted", {31'd0, halted}, 32'd1);
        rd_chk("R2 bgnd code", 2'd0, 32'h0000_0001);
        chk("R10 tmp read keeps cause", {31'd0, cause_valid}, 32'd1);
        rd_chk("R7 pcc bit0 cleared", 2'd3, 32'h0000_3000);
        chk("R10 cause cleared", {31'd0, cause_valid}, 32'd0);
        rd_chk("R10 tmp holds staged pcc", 2'd0, 32'h0000_3000);
        rd_chk("R7 rpc", 2'd2, 32'h0000_3004);
        rd_chk("R8 far", 2'd1, 32'h0000_2000);
        retire(32'h0000_5000, 32'h0000_5004);
        bus(32'h0000_6000);
        rd_chk("R7 retire ignored halted", 2'd3, 32'h0000_3000);
        rd_chk("R8 bus ignored halted", 2'd1, 32'h0000_2000);
        enter(1, 1, 1, 16'hBEEF, 1);
        rd_chk("R12 entry ignored halted", 2'd0, 32'h0000_2000);
        rd_chk("R6 pcc untouched by ignored entry", 2'd3, 32'h0000_3000);
        resume("R11", 32'h0000_3004, 1'b0);
    endtask

    task automatic t_breakpoint();
        enter(0, 1, 1, 16'h0, 0);
        rd_chk("R3 R5 bkpt over bgnd", 2'd0, 32'h0000_0000);
        resume("R11 bkpt", 32'h0000_3004, 1'b0);
        enter(1, 1, 1, 16'hA5C3, 0);
        rd_chk("R4 R5 dbl wins", 2'd0, 32'hA5C3_FFFF);
        resume("R11 dbl", 32'h0000_3004, 1'b0);
    endtask

    task automatic t_double_fault();
        retire(32'h0000_4010, 32'h0000_4014);
        bus(32'h0000_A000);
        bus(32'h0000_A100);
        enter(1, 0, 0, 16'h0042, 0);
        rd_chk("R4 dbl code", 2'd0, 32'h0042_FFFF);
        rd_chk("R6 pcc keeps last retire", 2'd3, 32'h0000_4010);
        rd_chk("R8 far last bus cycle", 2'd1, 32'h0000_A100);
        resume("R11 after dbl", 32'h0000_4014, 1'b0);
        ent_dbl_fault = 1; init_fetch = 1; ssw_in = 16'h7001;
        bus_cyc_valid = 1; bus_cyc_addr = 32'h0000_7777;
        retire_valid = 1; retire_pc = 32'h0000_8000; retire_next_pc = 32'h0000_8004;
        step();
        ent_dbl_fault = 0; init_fetch = 0; bus_cyc_valid = 0; retire_valid = 0;
        rd_chk("R6 init fetch marker", 2'd3, 32'hFFFF_FFFF);
        rd_chk("R8 coincident bus cycle", 2'd1, 32'h0000_7777);
        rd_chk("R7 coincident retire rpc", 2'd2, 32'h0000_8004);
        resume("R11 init fault", 32'h0000_8004, 1'b0);
    endtask

    task automatic t_port();
        logic [31:0] v;
        logic        k;
        rd(2'd2, v, k);
        chk("R9 no rvalid while running", {31'd0, k}, 32'd0);
        wr(2'd2, 32'h1111_0000);
        enter(0, 1, 0, 16'h0, 0);
        rd_chk("R9 write ignored running", 2'd2, 32'h0000_8004);
        wr(2'd2, 32'h0000_9001);
        wr(2'd3, 32'h0000_5555);
        rd_chk("R10 tmp staged write data", 2'd0, 32'h0000_5555);
        rd_chk("R7 pcc write bit0 cleared", 2'd3, 32'h0000_5554);
        wr(2'd1, 32'h0000_ABCD);
        rd_chk("R9 far written", 2'd1, 32'h0000_ABCD);
        step();
        chk("R9 rvalid single pulse", {31'd0, dbg_rvalid}, 32'd0);
        resume("R11 odd rpc", 32'h0000_9001, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_background();
        t_breakpoint();
        t_double_fault();
        t_port();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule